// File: doc/BRIEF.md
# Counted Serial Result Shifter

This block is the read-out port of a sampling converter. The conversion sequencer hands it a finished result word with a one-cycle strobe. The block holds that word until an external host clocks it out on a single serial data line. A rising edge on the start input has three roles: it enables the port, it selects this device on a shared line, and it clears the clock counter. After that edge the host applies serial clock pulses, and the block presents one bit per rising serial-clock edge, most significant bit first. The output enable drops on the falling edge of the last clock of the word. Any serial clocks that follow are ignored until the next start edge re-arms the port.

The result a read returns depends on when the read begins. A read begins on its first rising serial-clock edge. It returns the newest word committed before that edge. A strobe that arrives while a read is in progress is parked, and the parked word is committed only when that read ends or is aborted. The port depends only on its own inputs, so it keeps working while the converter core is powered down. All inputs are sampled in the block's `clk` domain. A parameterised synchroniser sits ahead of edge detection.

Top module: `ser_shift_top`

## Requirements
- R1: After reset the output enable is low, the data line is 0, and the committed result word is all zeros.
- R2: Serial clock edges produce no output unless a rising start edge has armed the port. While the enable is low, the data line reads 0.
- R3: After arming, the first rising serial-clock edge drives the output enable high and presents bit W-1 of the word. Each later rising edge presents the next lower bit.
- R4: The data line changes only in response to a rising serial-clock edge. It holds its value across the falling edge that follows.
- R5: The output enable stays high through the high phase of the W-th clock. It drops on that clock's falling edge.
- R6: After the W-th falling edge, further serial clocks leave the enable low and the data line at 0 until the next rising start edge.
- R7: A word strobed after arming but before the first rising serial-clock edge is the word that read shifts out.
- R8: A word strobed during a read does not disturb that read, which shifts out the previous word. The next read shifts out the new word.
- R9: A rising start edge during a read aborts it: the enable drops and the clock count restarts. The next read begins again from bit W-1.
- R10: Reads work the same way with a free-running clock, with gaps between clock pulses, and with different clock periods.
- R11: Several strobes with no read in between leave the last strobed word as the one read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| start_i | input | 1 | Start / port enable / device select; the rising edge arms the port |
| res_valid_i | input | 1 | One-cycle strobe from the sequencer marking a finished result |
| res_data_i | input | W (8) | Result word, valid while the strobe is high |
| ser_data_o | output | 1 | Serial data bit, most significant bit first |
| ser_oe_o | output | 1 | Drive enable for the data pad; low means high impedance |

## Verification
The assertions take for granted that the serial clock and the start input each stay at a level for more clock cycles than the synchroniser depth plus one. This means a rising and a falling edge of the same input are never seen in the same cycle, and the count and output checks line up with the detected edges. They also assume the strobe lasts exactly one cycle. The bench holds each serial-clock phase for at least five block clocks and each start level for six. It drives the strobe for a single cycle, between negative edges of the block clock. It samples late in each phase, well after the synchroniser and output-register latency.

// File: rtl/ser_shift_pkg.sv
package ser_shift_pkg;

    typedef enum logic [1:0] {
        PORT_OFF   = 2'd0,
        PORT_ARMED = 2'd1,
        PORT_SHIFT = 2'd2
    } port_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic int unsigned count_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ser_shift_edge.sv
module ser_shift_edge
    import ser_shift_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output edge_ev_t ev
);
    logic level;
    logic prev;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign level = din;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0 : 0], din} & {SYNC_STAGES{1'b1}};
            end
            assign level = chain[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    assign ev.rise = level & ~prev;
    assign ev.fall = ~level & prev;

endmodule

// File: rtl/ser_shift_ctrl.sv
module ser_shift_ctrl
    import ser_shift_pkg::*;
#(
    parameter int unsigned W  = 8,
    localparam int unsigned CW = count_width(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  edge_ev_t      sclk_ev,
    input  edge_ev_t      start_ev,
    output logic          load_o,
    output logic          shift_o,
    output logic          finish_o,
    output logic          abort_o,
    output logic          busy_o,
    output logic          oe_o,
    output logic [CW-1:0] cnt_o
);
    localparam logic [CW-1:0] LAST = CW'(W);

    port_state_e   state;
    logic [CW-1:0] cnt;
    logic          oe_q;

    always_comb begin
        load_o   = (state == PORT_ARMED) && sclk_ev.rise && !start_ev.rise;
        shift_o  = (state == PORT_SHIFT) && sclk_ev.rise && (cnt < LAST) && !start_ev.rise;
        finish_o = (state == PORT_SHIFT) && sclk_ev.fall && (cnt == LAST) && !start_ev.rise;
        abort_o  = (state == PORT_SHIFT) && start_ev.rise;
        busy_o   = (state == PORT_SHIFT) || load_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PORT_OFF;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else if (start_ev.rise) begin
            state <= PORT_ARMED;
            cnt   <= '0;
            oe_q  <= 1'b0;
        end else if (load_o) begin
            state <= PORT_SHIFT;
            cnt   <= CW'(1);
            oe_q  <= 1'b1;
        end else if (shift_o) begin
            cnt   <= cnt + CW'(1);
        end else if (finish_o) begin
            state <= PORT_OFF;
            oe_q  <= 1'b0;
        end
    end

    assign oe_o  = oe_q;
    assign cnt_o = cnt;

endmodule

// File: rtl/ser_shift_store.sv
module ser_shift_store #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    input  logic         busy_i,
    input  logic         release_i,
    output logic [W-1:0] latest_o,
    output logic         pend_o
);
    logic [W-1:0] latest;
    logic [W-1:0] parked;
    logic         pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            latest <= '0;
            parked <= '0;
            pend   <= 1'b0;
        end else if (release_i) begin
            if (valid_i)   latest <= data_i;
            else if (pend) latest <= parked;
            pend <= 1'b0;
        end else if (valid_i) begin
            if (busy_i) begin
                parked <= data_i;
                pend   <= 1'b1;
            end else begin
                latest <= data_i;
            end
        end
    end

    assign latest_o = latest;
    assign pend_o   = pend;

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic [W-1:0] word_i,
    output logic         bit_o
);
    logic [W-1:0] sh;
    logic         cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cur <= 1'b0;
        end else if (load_i) begin
            cur <= word_i[W-1];
            sh  <= {word_i[W-2:0], 1'b0};
        end else if (shift_i) begin
            cur <= sh[W-1];
            sh  <= {sh[W-2:0], 1'b0};
        end
    end

    assign bit_o = cur;

endmodule

// File: rtl/ser_shift_top.sv
module ser_shift_top
    import ser_shift_pkg::*;
#(
    parameter int unsigned W           = 8,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned CW = count_width(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk_i,
    input  logic         start_i,
    input  logic         res_valid_i,
    input  logic [W-1:0] res_data_i,
    output logic         ser_data_o,
    output logic         ser_oe_o
);
    edge_ev_t      sclk_ev;
    edge_ev_t      start_ev;
    logic          load, shift, finish, abort, busy, oe;
    logic [CW-1:0] cnt;
    logic [W-1:0]  latest;
    logic          pend;
    logic          bit_q;
    logic          sclk_rise, sclk_fall, start_rise;

    ser_shift_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sclk_edge (
        .clk(clk), .rst(rst), .din(ser_clk_i), .ev(sclk_ev)
    );

    ser_shift_edge #(.SYNC_STAGES(SYNC_STAGES)) u_start_edge (
        .clk(clk), .rst(rst), .din(start_i), .ev(start_ev)
    );

    ser_shift_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst(rst), .sclk_ev(sclk_ev), .start_ev(start_ev),
        .load_o(load), .shift_o(shift), .finish_o(finish), .abort_o(abort),
        .busy_o(busy), .oe_o(oe), .cnt_o(cnt)
    );

    ser_shift_store #(.W(W)) u_store (
        .clk(clk), .rst(rst), .valid_i(res_valid_i), .data_i(res_data_i),
        .busy_i(busy), .release_i(finish | abort),
        .latest_o(latest), .pend_o(pend)
    );

    ser_shift_reg #(.W(W)) u_reg (
        .clk(clk), .rst(rst), .load_i(load), .shift_i(shift),
        .word_i(latest), .bit_o(bit_q)
    );

    assign sclk_rise  = sclk_ev.rise;
    assign sclk_fall  = sclk_ev.fall;
    assign start_rise = start_ev.rise;
    assign ser_oe_o   = oe;
    assign ser_data_o = oe & bit_q;

endmodule

// File: rtl/ser_shift_chk.sv
module ser_shift_chk #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          oe,
    input logic          sdo,
    input logic          sclk_rise,
    input logic          sclk_fall,
    input logic          start_rise,
    input logic [CW-1:0] cnt,
    input logic          pend,
    input logic          busy
);
    assert_quiet_line_R2: assert property (@(posedge clk) disable iff (rst)
        !oe |-> !sdo);

    assert_oe_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(oe) |-> $past(sclk_rise));

    assert_data_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (oe && $past(oe) && !$stable(sdo)) |-> $past(sclk_rise));

    assert_oe_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(oe) |-> ($past(sclk_fall && (cnt == CW'(W))) || $past(start_rise)));

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(W));

    assert_parked_in_read_R8: assert property (@(posedge clk) disable iff (rst)
        pend |-> busy);

endmodule

bind ser_shift_top ser_shift_chk #(.W(W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .oe(ser_oe_o), .sdo(ser_data_o),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .start_rise(start_rise),
    .cnt(cnt), .pend(pend), .busy(busy)
);

// File: tb/tb_ser_shift_top.sv
module tb_ser_shift_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_clk_i = 1'b0;
    logic         start_i = 1'b0;
    logic         res_valid_i = 1'b0;
    logic [W-1:0] res_data_i = '0;
    logic         ser_data_o;
    logic         ser_oe_o;

    int vecs = 0;
    int miss = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ser_shift_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk_i), .start_i(start_i),
        .res_valid_i(res_valid_i), .res_data_i(res_data_i),
        .ser_data_o(ser_data_o), .ser_oe_o(ser_oe_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vecs++;
        if (!ok) begin
            miss++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic post(input logic [W-1:0] v);
        @(negedge clk);
        res_valid_i = 1'b1;
        res_data_i  = v;
        @(negedge clk);
        res_valid_i = 1'b0;
    endtask

    task automatic arm();
        start_i = 1'b1; tick(6);
        start_i = 1'b0; tick(6);
    endtask

    // Clock out bits hi..lo of exp; bit 0 ending checks the enable drop.
    task automatic read_bits(input logic [W-1:0] exp, input int hi, input int lo,
                             input int hp, input int gap, input string req);
        for (int i = hi; i >= lo; i--) begin
            ser_clk_i = 1'b1; tick(hp - 1);
            check(ser_oe_o === 1'b1, {req, " R3 R5 enable high"}, ser_oe_o, 1);
            check(ser_data_o === exp[i], {req, " R3 bit"}, ser_data_o, exp[i]);
            tick(1);
            ser_clk_i = 1'b0; tick(hp - 1);
            if (i > 0)
                check(ser_data_o === exp[i], {req, " R4 held"}, ser_data_o, exp[i]);
            else
                check(ser_oe_o === 1'b0, {req, " R5 enable drop"}, ser_oe_o, 0);
            tick(1);
            tick(gap);
        end
    endtask

    task automatic idle_clocks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            ser_clk_i = 1'b1; tick(6);
            check(ser_oe_o === 1'b0 && ser_data_o === 1'b0, req, {ser_oe_o, ser_data_o}, 0);
            ser_clk_i = 1'b0; tick(6);
        end
    endtask

    task automatic t_reset();
        check(ser_oe_o === 1'b0 && ser_data_o === 1'b0, "R1 reset outputs", {ser_oe_o, ser_data_o}, 0);
        idle_clocks(2, "R2 clocks before arming");
        arm();
        read_bits(8'h00, 7, 0, 6, 0, "R1 reset word");
    endtask

    task automatic t_basic();
        post(8'hA5);
        arm();
        read_bits(8'hA5, 7, 0, 6, 0, "R3 basic A5");
        idle_clocks(3, "R6 extra clocks");
    endtask

    task automatic t_current();
        arm();
        post(8'h3C);
        read_bits(8'h3C, 7, 0, 5, 0, "R7 current word");
    endtask

    task automatic t_deferred();
        arm();
        read_bits(8'hC3 ^ 8'hFF, 7, 6, 6, 0, "R8 old word head");
        post(8'h96);
        read_bits(8'h3C, 5, 0, 6, 0, "R8 old word tail");
        arm();
        read_bits(8'h96, 7, 0, 6, 0, "R8 new word next read");
    endtask

    task automatic t_abort();
        post(8'h5A);
        arm();
        read_bits(8'h5A, 7, 5, 6, 0, "R9 partial");
        start_i = 1'b1; tick(6);
        check(ser_oe_o === 1'b0, "R9 abort drops enable", ser_oe_o, 0);
        start_i = 1'b0; tick(6);
        read_bits(8'h5A, 7, 0, 6, 0, "R9 restart from top");
    endtask

    task automatic t_gated();
        post(8'h81);
        arm();
        read_bits(8'h81, 7, 0, 7, 25, "R10 gated clock");
        post(8'h7E);
        arm();
        read_bits(8'h7E, 7, 0, 5, 0, "R10 fast clock");
    endtask

    task automatic t_overwrite();
        post(8'h11);
        post(8'h22);
        post(8'hE7);
        arm();
        read_bits(8'hE7, 7, 0, 6, 0, "R11 last strobe wins");
        idle_clocks(2, "R6 after read");
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_basic();
        t_current();
        t_deferred();
        t_abort();
        t_gated();
        t_overwrite();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vecs++;
            miss++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
            $finish;
        end
    end

endmodule